// File: doc/BRIEF.md
# Dual-Speed Peripheral Clock Enable Generator

This block holds one 8-bit clock-control register and turns it into single-cycle enable pulses: one machine-cycle enable for the CPU and one cycle enable for each of seven peripherals. The peripherals are two-wire serial, watchdog, counter array, UART (shift and fixed-rate modes), timer 2, timer 1 and timer 0. It gates no clock. Each consumer advances its own state only on the cycles where its enable is high.

A global speed bit selects the timing. With the bit clear, everything runs at 12 oscillator periods per cycle. With the bit set, the CPU runs at 6 periods per cycle, and each peripheral picks 6 or 12 periods through its own bit. All pulses come from one free-running modulo-12 phase counter, so fast and slow enables stay phase-aligned.

Register writes are staged until the phase counter wraps. A mode change therefore never shortens or stretches a cycle. A power-up configuration input gives the initial global speed bit.

Top module: `pclk_rate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all enables are low after that edge, and the register reads `{7'b0, cfg_dbl}`; bits 7..1 are cleared whatever they held before.
- R2: The phase counter restarts at reset. The first cycle after reset release is phase 0, where the CPU enable and every peripheral enable pulse together.
- R3: With register bit 0 clear, the CPU and all seven peripherals pulse once every 12 cycles, at phase 0 only. Bits 7..1 have no effect in this mode.
- R4: With register bit 0 set, the CPU enable pulses every 6 cycles, at phases 0 and 6.
- R5: With bit 0 set, a clear peripheral bit gives that peripheral pulses at phases 0 and 6, and a set bit gives a pulse at phase 0 only. The bit mapping is: bit 1 to `per_en[0]` (timer 0), bit 2 to `per_en[1]` (timer 1), bit 3 to `per_en[2]` (timer 2), bit 4 to `per_en[3]` (UART), bit 5 to `per_en[4]` (counter array), bit 6 to `per_en[5]` (watchdog), bit 7 to `per_en[6]` (two-wire serial).
- R6: A cycle with `sfr_we` high and `sfr_addr` equal to 8Fh stores all 8 bits of `sfr_wdata`. `sfr_rdata` shows the stored byte when the address is 8Fh, including bits that are currently ignored, and shows 00h for any other address. Writes to other addresses change nothing.
- R7: A stored value drives the enables from the next 12-cycle frame onward. This also holds for a write sampled in the last cycle of a frame (phase 11), so no enable ever sees a partial cycle.
- R8: Every enable is a single-cycle pulse; no enable is high in two consecutive cycles.
- R9: `cfg_dbl` is read only while reset is held. Changing it during operation has no effect on the register or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dbl | input | 1 | Power-up value of the global speed bit |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data |
| cpu_en | output | 1 | CPU machine-cycle enable |
| per_en | output | 7 | Peripheral enables: 0 timer 0, 1 timer 1, 2 timer 2, 3 UART, 4 counter array, 5 watchdog, 6 two-wire serial |

## Verification
Enable vectors are compared every cycle across frames with these register values:
- 00h, where all enables share one 12-cycle rate.
- FEh, where only ignored peripheral bits are set; this separates honouring from ignoring those bits.
- 01h, where everything is fast.
- 55h and ABh, alternating peripheral bits; these expose a swapped or shifted bit mapping.
- FFh, where the CPU is fast and all peripherals are slow.

Writes land at different phases, including phase 0, mid-frame and the final cycle of a frame, to show that the staging point is the frame boundary. A write and a read at a foreign address, a reset that follows an FFh write, and toggling of `cfg_dbl` outside reset cover storage, clearing and sampling of the configuration input.

// File: rtl/pclk_rate_gen.sv
module pclk_rate_gen #(
  parameter int unsigned NPER     = 7,
  parameter int unsigned DIV_STD  = 12,
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  CTL_ADDR = 8'h8F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_dbl,
  input  logic [AW-1:0]   sfr_addr,
  input  logic            sfr_we,
  input  logic [NPER:0]   sfr_wdata,
  output logic [NPER:0]   sfr_rdata,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en
);
  localparam int unsigned HALF = DIV_STD / 2;
  localparam int unsigned CW   = $clog2(DIV_STD);

  logic [CW-1:0]   cnt;
  logic [NPER:0]   ctl, act;
  logic [NPER-1:0] per_d;

  wire            addr_hit = (sfr_addr == AW'(CTL_ADDR));
  wire            wr_hit   = sfr_we && addr_hit;
  wire            wrap     = (cnt == CW'(DIV_STD - 1));
  wire            ph0      = (cnt == '0);
  wire            phh      = (cnt == CW'(HALF));
  wire [NPER:0]   ctl_nxt  = wr_hit ? sfr_wdata : ctl;
  wire [NPER:0]   rst_val  = {{NPER{1'b0}}, cfg_dbl};

  assign sfr_rdata = addr_hit ? ctl : '0;

  for (genvar i = 0; i < NPER; i++) begin : g_per
    assign per_d[i] = ph0 | (act[0] & ~act[i+1] & phh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ctl    <= rst_val;
      act    <= rst_val;
      cpu_en <= 1'b0;
      per_en <= '0;
    end else begin
      cnt    <= wrap ? '0 : cnt + CW'(1);
      ctl    <= ctl_nxt;
      if (wrap) act <= ctl_nxt;
      cpu_en <= ph0 | (act[0] & phh);
      per_en <= per_d;
    end
  end
endmodule

// File: rtl/pclk_rate_gen_chk.sv
module pclk_rate_gen_chk #(
  parameter int unsigned NPER     = 7,
  parameter int unsigned DIV_STD  = 12,
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  CTL_ADDR = 8'h8F,
  parameter int unsigned CW       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   sfr_addr,
  input logic            sfr_we,
  input logic [NPER:0]   sfr_wdata,
  input logic            cpu_en,
  input logic [NPER-1:0] per_en,
  input logic [CW-1:0]   cnt,
  input logic [NPER:0]   ctl,
  input logic [NPER:0]   act
);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DIV_STD));

  p_std_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !$past(act[0])) |-> (&per_en));

  p_per_with_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en != '0) |-> cpu_en);

  p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == AW'(CTL_ADDR)) |=> (ctl == $past(sfr_wdata)));

  p_single_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> !cpu_en);

  p_single_per_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en != '0) |=> (per_en == '0));
endmodule

bind pclk_rate_gen pclk_rate_gen_chk #(
  .NPER(NPER), .DIV_STD(DIV_STD), .AW(AW), .CTL_ADDR(CTL_ADDR), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
  .sfr_wdata(sfr_wdata), .cpu_en(cpu_en), .per_en(per_en),
  .cnt(cnt), .ctl(ctl), .act(act)
);

// File: tb/sim_pclk_rate_gen.sv
`timescale 1ns/1ps
module sim_pclk_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_dbl = 1'b0;
  logic [7:0] sfr_addr = 8'h8F;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       cpu_en;
  logic [6:0] per_en;

  int total = 0;
  int bad = 0;

  logic [7:0] exp_q[$];
  string      exp_tag_q[$];
  logic [7:0] rd_q[$];
  string      rd_tag_q[$];

  always #10 clk = ~clk;

  pclk_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .sfr_addr(sfr_addr),
    .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .cpu_en(cpu_en), .per_en(per_en)
  );

  function automatic logic [7:0] exp_vec(input logic [7:0] e, input int ph);
    logic [7:0] v;
    v[0] = (ph == 0) || (e[0] && ph == 6);
    for (int k = 1; k < 8; k++) v[k] = (ph == 0) || (e[0] && !e[k] && ph == 6);
    return v;
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag_q.pop_front();
        total++;
        if ({per_en, cpu_en} !== e) begin
          bad++;
          $display("FAIL %s enables actual=%b expected=%b t=%0t", t, {per_en, cpu_en}, e, $time);
        end
      end
      if (rd_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag_q.pop_front();
        total++;
        if (sfr_rdata !== e) begin
          bad++;
          $display("FAIL %s rdata actual=%h expected=%h t=%0t", t, sfr_rdata, e, $time);
        end
      end
    end
  end

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_dbl = cfg;
    sfr_we = 1'b0;
    sfr_addr = 8'h8F;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        exp_q.push_back(8'h00); exp_tag_q.push_back("R1");
        rd_q.push_back({7'b0, cfg}); rd_tag_q.push_back("R1");
      end
    end
    rst_n = 1'b1;
  endtask

  task automatic frame(input logic [7:0] eff, input string tag,
                       input bit wr, input logic [7:0] wa, input logic [7:0] wd,
                       input int wat, input logic [7:0] ra, input logic [7:0] rexp,
                       input string rtag);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) begin
        sfr_addr = 8'h8F;
        for (int ph = 0; ph < 12; ph++) begin
          exp_q.push_back(exp_vec(eff, ph)); exp_tag_q.push_back(tag);
        end
      end
      if (wr && i == wat) begin
        sfr_we = 1'b1; sfr_addr = wa; sfr_wdata = wd;
      end else if (wr && i == wat + 1) begin
        sfr_we = 1'b0; sfr_addr = 8'h8F;
      end
      if (i == 11) begin
        sfr_addr = ra;
        rd_q.push_back(rexp); rd_tag_q.push_back(rtag);
      end
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    do_reset(1'b0);
    frame(8'h00, "R2", 0, 8'h8F, 8'h00, 0, 8'h8F, 8'h00, "R6");
    cfg_dbl = 1'b1;  // R9: ignored outside reset
    frame(8'h00, "R9", 1, 8'h8F, 8'hFE, 3, 8'h8F, 8'hFE, "R6");
    frame(8'hFE, "R3", 1, 8'h8F, 8'h01, 10, 8'h8F, 8'h01, "R6");
    frame(8'h01, "R7", 1, 8'h8F, 8'h55, 7, 8'h8F, 8'h55, "R6");
    frame(8'h55, "R5", 1, 8'h8E, 8'h00, 2, 8'h8E, 8'h00, "R6");
    frame(8'h55, "R6", 1, 8'h8F, 8'hAB, 0, 8'h8F, 8'hAB, "R6");
    frame(8'hAB, "R5", 1, 8'h8F, 8'hFF, 5, 8'h8F, 8'hFF, "R6");
    frame(8'hFF, "R4", 1, 8'h8F, 8'h00, 6, 8'h8F, 8'h00, "R6");
    frame(8'h00, "R7", 1, 8'h8F, 8'hFF, 4, 8'h8F, 8'hFF, "R6");
    frame(8'hFF, "R8", 0, 8'h8F, 8'h00, 0, 8'h8F, 8'hFF, "R6");
    do_reset(1'b1);
    frame(8'h01, "R1", 0, 8'h8F, 8'h00, 0, 8'h8F, 8'h01, "R1");
    cfg_dbl = 1'b0;  // R9
    frame(8'h01, "R9", 0, 8'h8F, 8'h00, 0, 8'h8F, 8'h01, "R9");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule